// File: doc/BRIEF.md
# Interrupt Acknowledge Priority Unit

This unit is the acknowledge path of one CPU interface inside a prioritised interrupt controller. Another part of the controller finds the highest pending interrupt and presents its ID, its 8-bit priority and its group bit. When the CPU issues an acknowledge read, the unit decides whether that interrupt may preempt the work that is already running. If it may, the unit returns the ID word, marks the interrupt active, records the preemption level in an active-priority bank and lowers the running priority.

Preemption is judged on a group priority. The group priority is the interrupt priority with its low bits masked away by a binary point setting. The binary point is either the main one or, for group-1 interrupts, a separate one. Software-generated interrupts keep one pending bit per source CPU in the unit. Each acknowledge consumes the lowest-numbered source and reports it in the upper bits of the returned word.

Top module: `irq_ack_unit`

## Requirements
- R1: The group priority is the pending priority ANDed with the low 8 bits of an all-ones value shifted left by (binary point + 1). A binary point of 0 keeps bits [7:1] and a binary point of 7 keeps none.
- R2: When `grp_en` is 1, `cbpr` is 0 and `pend_grp1` is 1, the binary point used is (`abpr` - 1) mod 8. In every other case it is `bpr`.
- R3: An acknowledge with `pend_id` of 1020 or more returns `pend_id` unchanged. It raises neither `act_valid` nor `pend_clr`, and it leaves the running priority, the active-priority banks and the source bitmaps as they were.
- R4: An acknowledge whose `pend_prio` is greater than or equal to the running priority returns 1023 and changes no state.
- R5: A successful acknowledge sets exactly one active-priority bit, at flat index level = group priority >> 1. That index is bit (level mod 32) of 32-bit word (level / 32). Bits stay set until reset.
- R6: The bit goes to `apr_g1` when `grp_en` and `pend_grp1` are both 1, and to `apr_g0` otherwise.
- R7: The running priority resets to 0xFF. After a successful acknowledge it equals the group priority. `rp_load` writes `rp_value` into it when no acknowledge is activating in the same cycle.
- R8: For IDs 0 to 15 the source returned is the lowest set bit of that interrupt's source bitmap. The word is ID | (source << 10), so the source sits in bits [12:10]. That bitmap bit is then cleared.
- R9: `pend_clr` pulses with `pend_clr_id` for every activated ID of 16 or more. For IDs 0 to 15 it pulses only when the source bitmap becomes empty. `sgi_pending[n]` is the OR of the bitmap of interrupt n.
- R10: `ack_valid` is high for exactly the one cycle after an `ack_rd` cycle, and all state changes take effect on that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_rd | input | 1 | Acknowledge read strobe |
| pend_id | input | 10 | Highest pending interrupt ID |
| pend_prio | input | 8 | Priority of that interrupt |
| pend_grp1 | input | 1 | That interrupt is in group 1 |
| grp_en | input | 1 | Interrupt grouping present |
| cbpr | input | 1 | Use the main binary point for both groups |
| bpr | input | 3 | Main binary point |
| abpr | input | 3 | Group-1 binary point |
| rp_load | input | 1 | Load running priority (priority drop) |
| rp_value | input | 8 | Value for rp_load |
| sgi_raise | input | 1 | Raise a software-generated interrupt |
| sgi_raise_id | input | 4 | Its ID |
| sgi_raise_src | input | 3 | Its source CPU |
| ack_valid | output | 1 | Acknowledge data valid |
| ack_data | output | 13 | Returned ID word |
| act_valid | output | 1 | Interrupt made active this cycle |
| act_id | output | 10 | ID made active |
| pend_clr | output | 1 | Clear the distributor pending flag |
| pend_clr_id | output | 10 | ID whose pending flag is cleared |
| running_prio | output | 8 | Current running priority |
| sgi_pending | output | 16 | Per-SGI overall pending flag |
| apr_g0 | output | 128 | Group-0 active-priority bank, four 32-bit words |
| apr_g1 | output | 128 | Group-1 active-priority bank, four 32-bit words |

## Verification
The hardest case to reach is an SGI raised by two sources, acknowledged twice with a priority drop in between. Only the second acknowledge may clear the pending flag, and each acknowledge must report a different source. The stimulus raises sources 6 and 3 in that order, so that the lowest-set-bit choice differs from arrival order. It then reloads the running priority between the two acknowledges. The edge of the binary point wrap (`abpr` of 0 giving a mask of zero) is reached by lowering the running priority first, so that a group-1 interrupt can still preempt.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int ID_W        = 10;
  localparam int PRIO_W      = 8;
  localparam int BP_W        = 3;
  localparam int SRC_LSB     = 10;
  localparam int SPURIOUS_ID = 1023;
  localparam int MAX_IRQ     = 1020;
endpackage

// File: rtl/irq_ack_grpprio.sv
module irq_ack_grpprio #(
  parameter int PRIO_W  = 8,
  parameter int BP_W    = 3,
  parameter int MIN_BPR = 0,
  parameter int LVL_W   = PRIO_W - 1 - MIN_BPR
) (
  input  logic [PRIO_W-1:0] prio,
  input  logic [BP_W-1:0]   bpr,
  input  logic [BP_W-1:0]   abpr,
  input  logic              cbpr,
  input  logic              grp_en,
  input  logic              grp1,
  output logic [PRIO_W-1:0] gprio,
  output logic              use_g1,
  output logic [LVL_W-1:0]  level
);
  localparam int SH_W = BP_W + 1;

  logic [BP_W-1:0] bsel;
  logic [SH_W-1:0] shamt;
  logic [PRIO_W:0] wide;
  logic [PRIO_W-1:0] shifted;

  always_comb begin
    use_g1  = grp_en & grp1;
    bsel    = (use_g1 && !cbpr) ? (abpr - BP_W'(1)) : bpr;
    shamt   = {1'b0, bsel} + SH_W'(1);
    wide    = {(PRIO_W+1){1'b1}} << shamt;
    gprio   = prio & wide[PRIO_W-1:0];
    shifted = gprio >> (MIN_BPR + 1);
    level   = shifted[LVL_W-1:0];
  end
endmodule

// File: rtl/irq_ack_sgi_src.sv
module irq_ack_sgi_src #(
  parameter int NUM_SGI = 16,
  parameter int NUM_SRC = 8,
  parameter int SGI_W   = $clog2(NUM_SGI),
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_v,
  input  logic [SGI_W-1:0]   set_id,
  input  logic [SRC_W-1:0]   set_src,
  input  logic               take_v,
  input  logic [SGI_W-1:0]   take_id,
  output logic [SRC_W-1:0]   src,
  output logic               last,
  output logic [NUM_SGI-1:0] pending
);
  logic [NUM_SRC-1:0] map_q [NUM_SGI];
  logic [NUM_SRC-1:0] sel;

  for (genvar g = 0; g < NUM_SGI; g++) begin : g_sgi
    always_ff @(posedge clk) begin
      if (rst) begin
        map_q[g] <= '0;
      end else begin
        if (take_v && take_id == SGI_W'(g)) map_q[g][src] <= 1'b0;
        if (set_v && set_id == SGI_W'(g))   map_q[g][set_src] <= 1'b1;
      end
    end
    assign pending[g] = |map_q[g];
  end

  always_comb begin
    sel = map_q[take_id];
    src = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (sel[i]) src = SRC_W'(i);
    end
    last = ((sel & ~(NUM_SRC'(1) << src)) == '0);
  end

  AST_SGI_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (take_v && !(set_v && set_id == take_id && set_src == src))
      |=> !map_q[$past(take_id)][$past(src)]); // R8

  AST_SGI_SET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    set_v |=> pending[$past(set_id)]); // R9
endmodule

// File: rtl/irq_ack_apr.sv
module irq_ack_apr #(
  parameter int LEVELS = 128,
  parameter int APR_W  = 32,
  parameter int LVL_W  = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_v,
  input  logic              set_g1,
  input  logic [LVL_W-1:0]  level,
  output logic [LEVELS-1:0] apr_g0,
  output logic [LEVELS-1:0] apr_g1
);
  localparam int NREG  = LEVELS / APR_W;
  localparam int BIT_W = $clog2(APR_W);
  localparam int REG_W = LVL_W - BIT_W;

  logic [APR_W-1:0] bank_q [2][NREG];
  logic [REG_W-1:0] reg_idx;
  logic [BIT_W-1:0] bit_idx;

  assign reg_idx = level[LVL_W-1:BIT_W];
  assign bit_idx = level[BIT_W-1:0];

  for (genvar grp = 0; grp < 2; grp++) begin : g_grp
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          bank_q[grp][r] <= '0;
        end else if (set_v && (set_g1 == (grp == 1)) && reg_idx == REG_W'(r)) begin
          bank_q[grp][r][bit_idx] <= 1'b1;
        end
      end
      if (grp == 0) begin : g_o0
        assign apr_g0[r*APR_W +: APR_W] = bank_q[grp][r];
      end else begin : g_o1
        assign apr_g1[r*APR_W +: APR_W] = bank_q[grp][r];
      end
    end
  end

  AST_APR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((apr_g0 & $past(apr_g0)) == $past(apr_g0)) &&
    ((apr_g1 & $past(apr_g1)) == $past(apr_g1))); // R5

  AST_APR_ONE_NEW: assert property (@(posedge clk) disable iff (rst)
    $countones({apr_g0, apr_g1} ^ $past({apr_g0, apr_g1})) <= 1); // R5

  AST_APR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !set_v |=> ($stable(apr_g0) && $stable(apr_g1))); // R3
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_ack_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int NUM_SRC = 8,
  parameter int MIN_BPR = 0,
  parameter int APR_W   = 32,
  parameter int SGI_W   = $clog2(NUM_SGI),
  parameter int SRC_W   = $clog2(NUM_SRC),
  parameter int LVL_W   = PRIO_W - 1 - MIN_BPR,
  parameter int LEVELS  = 1 << LVL_W,
  parameter int ACK_W   = SRC_LSB + SRC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack_rd,
  input  logic [ID_W-1:0]    pend_id,
  input  logic [PRIO_W-1:0]  pend_prio,
  input  logic               pend_grp1,
  input  logic               grp_en,
  input  logic               cbpr,
  input  logic [BP_W-1:0]    bpr,
  input  logic [BP_W-1:0]    abpr,
  input  logic               rp_load,
  input  logic [PRIO_W-1:0]  rp_value,
  input  logic               sgi_raise,
  input  logic [SGI_W-1:0]   sgi_raise_id,
  input  logic [SRC_W-1:0]   sgi_raise_src,
  output logic               ack_valid,
  output logic [ACK_W-1:0]   ack_data,
  output logic               act_valid,
  output logic [ID_W-1:0]    act_id,
  output logic               pend_clr,
  output logic [ID_W-1:0]    pend_clr_id,
  output logic [PRIO_W-1:0]  running_prio,
  output logic [NUM_SGI-1:0] sgi_pending,
  output logic [LEVELS-1:0]  apr_g0,
  output logic [LEVELS-1:0]  apr_g1
);
  logic [PRIO_W-1:0] gprio;
  logic              use_g1;
  logic [LVL_W-1:0]  level;
  logic              id_ok, may_preempt, is_sgi, activate, take_sgi;
  logic [SRC_W-1:0]  sgi_src;
  logic              sgi_last;
  logic [ACK_W-1:0]  word;

  irq_ack_grpprio #(.PRIO_W(PRIO_W), .BP_W(BP_W), .MIN_BPR(MIN_BPR), .LVL_W(LVL_W)) u_grp (
    .prio(pend_prio), .bpr(bpr), .abpr(abpr), .cbpr(cbpr), .grp_en(grp_en),
    .grp1(pend_grp1), .gprio(gprio), .use_g1(use_g1), .level(level)
  );

  always_comb begin
    id_ok       = (pend_id < ID_W'(MAX_IRQ));
    may_preempt = (pend_prio < running_prio);
    is_sgi      = (pend_id < ID_W'(NUM_SGI));
    activate    = ack_rd && id_ok && may_preempt;
    take_sgi    = activate && is_sgi;
    if (!id_ok)             word = ACK_W'(pend_id);
    else if (!may_preempt)  word = ACK_W'(SPURIOUS_ID);
    else if (is_sgi)        word = ACK_W'(pend_id) | (ACK_W'(sgi_src) << SRC_LSB);
    else                    word = ACK_W'(pend_id);
  end

  irq_ack_sgi_src #(.NUM_SGI(NUM_SGI), .NUM_SRC(NUM_SRC), .SGI_W(SGI_W), .SRC_W(SRC_W)) u_sgi (
    .clk(clk), .rst(rst), .set_v(sgi_raise), .set_id(sgi_raise_id), .set_src(sgi_raise_src),
    .take_v(take_sgi), .take_id(pend_id[SGI_W-1:0]), .src(sgi_src), .last(sgi_last),
    .pending(sgi_pending)
  );

  irq_ack_apr #(.LEVELS(LEVELS), .APR_W(APR_W), .LVL_W(LVL_W)) u_apr (
    .clk(clk), .rst(rst), .set_v(activate), .set_g1(use_g1), .level(level),
    .apr_g0(apr_g0), .apr_g1(apr_g1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid    <= 1'b0;
      ack_data     <= '0;
      act_valid    <= 1'b0;
      act_id       <= '0;
      pend_clr     <= 1'b0;
      pend_clr_id  <= '0;
      running_prio <= '1;
    end else begin
      ack_valid <= ack_rd;
      if (ack_rd) ack_data <= word;
      act_valid <= activate;
      if (activate) act_id <= pend_id;
      pend_clr <= activate && (!is_sgi || sgi_last);
      if (activate) pend_clr_id <= pend_id;
      if (activate)     running_prio <= gprio;
      else if (rp_load) running_prio <= rp_value;
    end
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> ack_valid); // R10
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ack_rd |=> !ack_valid); // R10
  AST_SPUR_NO_ACT: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_data == ACK_W'(SPURIOUS_ID)) |-> !act_valid); // R4
  AST_RP_DROPS: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> (running_prio < $past(running_prio))); // R7
  AST_CLR_NEEDS_ACT: assert property (@(posedge clk) disable iff (rst)
    pend_clr |-> act_valid); // R9
  AST_BAD_ID_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !id_ok) |=> !act_valid); // R3
endmodule

// File: tb/irq_ack_unit_tb.sv
module irq_ack_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack_rd = 0, pend_grp1 = 0, grp_en = 0, cbpr = 0, rp_load = 0, sgi_raise = 0;
  logic [9:0] pend_id = '0;
  logic [7:0] pend_prio = '0, rp_value = '0;
  logic [2:0] bpr = '0, abpr = '0, sgi_raise_src = '0;
  logic [3:0] sgi_raise_id = '0;
  logic ack_valid, act_valid, pend_clr;
  logic [12:0] ack_data;
  logic [9:0] act_id, pend_clr_id;
  logic [7:0] running_prio;
  logic [15:0] sgi_pending;
  logic [127:0] apr_g0, apr_g1;

  int errors = 0, checks = 0;
  logic [7:0]   m_rp = 8'hFF;
  logic [127:0] m_a0 = '0, m_a1 = '0;
  logic [7:0]   m_map [16];
  logic [12:0]  exq [$];
  string        tagq [$];

  always #10 clk = ~clk;

  irq_ack_unit u_dut (
    .clk(clk), .rst(rst), .ack_rd(ack_rd), .pend_id(pend_id), .pend_prio(pend_prio),
    .pend_grp1(pend_grp1), .grp_en(grp_en), .cbpr(cbpr), .bpr(bpr), .abpr(abpr),
    .rp_load(rp_load), .rp_value(rp_value), .sgi_raise(sgi_raise),
    .sgi_raise_id(sgi_raise_id), .sgi_raise_src(sgi_raise_src), .ack_valid(ack_valid),
    .ack_data(ack_data), .act_valid(act_valid), .act_id(act_id), .pend_clr(pend_clr),
    .pend_clr_id(pend_clr_id), .running_prio(running_prio), .sgi_pending(sgi_pending),
    .apr_g0(apr_g0), .apr_g1(apr_g1)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_pend();
    logic [15:0] p;
    for (int i = 0; i < 16; i++) p[i] = |m_map[i];
    return p;
  endfunction

  // Monitor: compares each returned word with the scoreboard head
  always @(negedge clk) begin
    if (!rst && ack_valid) begin
      if (exq.size() == 0) chk(1'b0, "R10 unexpected ack_valid", 128'(ack_data), 0);
      else begin
        logic [12:0] e;
        string t;
        e = exq.pop_front();
        t = tagq.pop_front();
        chk(ack_data == e, t, 128'(ack_data), 128'(e));
      end
    end
  end

  task automatic raise(input int id, input int src);
    @(negedge clk);
    sgi_raise = 1; sgi_raise_id = 4'(id); sgi_raise_src = 3'(src);
    m_map[id][src] = 1'b1;
    @(negedge clk);
    sgi_raise = 0;
  endtask

  task automatic load_rp(input logic [7:0] v);
    @(negedge clk);
    rp_load = 1; rp_value = v; m_rp = v;
    @(negedge clk);
    rp_load = 0;
    chk(running_prio == v, "R7 rp_load", 128'(running_prio), 128'(v));
  endtask

  task automatic do_ack(input int id, input int prio, input bit g1, input string tag);
    logic [12:0] w;
    bit act, clr, useg1;
    int b, lvl, src;
    logic [7:0] mask, gp;
    @(negedge clk);
    pend_id = 10'(id); pend_prio = 8'(prio); pend_grp1 = g1; ack_rd = 1;
    act = 0; clr = 0;
    if (id >= 1020) w = 13'(id);
    else if (prio >= m_rp) w = 13'd1023;
    else begin
      act = 1;
      useg1 = grp_en && g1;
      b = (useg1 && !cbpr) ? ((abpr + 7) % 8) : bpr;
      mask = 8'((9'h1FF << (b + 1)) & 9'h0FF);
      gp = 8'(prio) & mask;
      lvl = gp >> 1;
      if (useg1) m_a1[lvl] = 1'b1; else m_a0[lvl] = 1'b1;
      m_rp = gp;
      if (id < 16) begin
        src = 0;
        for (int i = 7; i >= 0; i--) if (m_map[id][i]) src = i;
        m_map[id][src] = 1'b0;
        clr = (m_map[id] == 0);
        w = 13'(id) | 13'(src << 10);
      end else begin
        clr = 1;
        w = 13'(id);
      end
    end
    exq.push_back(w);
    tagq.push_back({tag, " ack word"});
    @(negedge clk);
    ack_rd = 0;
    chk(act_valid == act, {tag, " act_valid"}, 128'(act_valid), 128'(act));
    if (act) chk(act_id == 10'(id), {tag, " act_id"}, 128'(act_id), 128'(id));
    chk(pend_clr == clr, {tag, " R9 pend_clr"}, 128'(pend_clr), 128'(clr));
    if (clr) chk(pend_clr_id == 10'(id), {tag, " R9 pend_clr_id"}, 128'(pend_clr_id), 128'(id));
    chk(running_prio == m_rp, {tag, " R7 running_prio"}, 128'(running_prio), 128'(m_rp));
    chk(apr_g0 == m_a0, {tag, " R5 apr_g0"}, apr_g0, m_a0);
    chk(apr_g1 == m_a1, {tag, " R6 apr_g1"}, apr_g1, m_a1);
    chk(sgi_pending == m_pend(), {tag, " R9 sgi_pending"}, 128'(sgi_pending), 128'(m_pend()));
    @(negedge clk);
    chk(!ack_valid && exq.size() == 0, {tag, " R10 single-cycle valid"}, 128'(ack_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_map[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(running_prio == 8'hFF, "R7 reset running_prio", 128'(running_prio), 128'hFF);
    chk(!ack_valid && !act_valid && !pend_clr, "R10 reset strobes", 128'(ack_valid), 0);
    chk(apr_g0 == 0 && apr_g1 == 0, "R5 reset banks", apr_g0 | apr_g1, 0);
    chk(sgi_pending == 0, "R9 reset sgi_pending", 128'(sgi_pending), 0);

    // R1: main binary point 2 -> mask F8, 0x85 -> 0x80, level 64
    bpr = 3'd2;
    do_ack(40, 8'h85, 1'b0, "R1 bpr2");
    // R4: equal priority to running -> spurious
    do_ack(41, 8'h80, 1'b0, "R4 equal prio");
    do_ack(42, 8'h90, 1'b0, "R4 lower prio");
    // R3: invalid IDs returned unchanged
    do_ack(1021, 8'h00, 1'b0, "R3 id 1021");
    do_ack(1020, 8'h00, 1'b1, "R3 id 1020");
    // R2: group 1, separate binary point 3 -> effective 2
    load_rp(8'hFF);
    grp_en = 1; cbpr = 0; bpr = 3'd0; abpr = 3'd3;
    do_ack(100, 8'h47, 1'b1, "R2 abpr3");
    // R1 edge: abpr 0 wraps to 7 -> mask 0, level 0
    abpr = 3'd0;
    do_ack(101, 8'h21, 1'b1, "R1 abpr0 wrap");
    // R2: combined binary point uses bpr for group 1
    load_rp(8'hFF);
    cbpr = 1;
    do_ack(102, 8'h33, 1'b1, "R2 cbpr");
    // R6: grouping absent sends group-1 interrupt to bank 0
    load_rp(8'hFF);
    grp_en = 0; cbpr = 0; bpr = 3'd1;
    do_ack(103, 8'h0F, 1'b1, "R6 no grouping");
    // R1 top binary point on bank 0 with bpr 7 (mask 0)
    load_rp(8'hFF);
    bpr = 3'd7;
    do_ack(200, 8'hFE, 1'b0, "R1 bpr7");
    // R8/R9: two sources raised out of order
    load_rp(8'hFF);
    bpr = 3'd0;
    raise(5, 6);
    raise(5, 3);
    chk(sgi_pending[5], "R9 raised pending", 128'(sgi_pending), 128'(16'h0020));
    do_ack(5, 8'h60, 1'b0, "R8 first source");
    load_rp(8'hFF);
    do_ack(5, 8'h60, 1'b0, "R8 second source");
    // R8: source 0 on a different SGI, immediate clear
    load_rp(8'hFF);
    raise(15, 0);
    do_ack(15, 8'hA4, 1'b0, "R8 sgi15 src0");
    // R4: spurious SGI acknowledge consumes no source
    raise(2, 7);
    do_ack(2, 8'hF0, 1'b0, "R4 sgi spurious");
    load_rp(8'hFF);
    do_ack(2, 8'h10, 1'b0, "R8 sgi2 src7");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule